// File: doc/BRIEF.md
# Bridge Outbound Address Translator

This block sits between a local bus and a PCI bus inside a bus bridge. It holds one writable upper-address register for each of several outbound address windows. When a local-bus access hits one of the windows, the block builds the PCI address combinationally. The bits above the window's size come from that window's register. The bits inside the window's size come straight from the local-bus address. Each window's size is fixed when the design is elaborated, as a mask of ones that starts at bit 0.

The block also keeps the bridge's own device number as a host bridge. It decodes that number into a one-hot vector that names the address bit wired to the bridge's own configuration select line. This register exists only when both the configuration feature and the device-number feature are enabled. A write that asks for a device number beyond the supported count is dropped.

Software reaches all registers through a simple single-cycle write port and a combinational read port that uses a word index. Windows sit at indexes 0 to NUM_WIN-1, and the device number sits at index NUM_WIN. The block has no state machine: the only state is the registers themselves, each with two states, reset and loaded.

Top module: `pci_xlat_regs`

## Requirements
- R1: After reset every window register reads 0. A write with `reg_wr`=1 and `reg_addr`=i (i < NUM_WIN) loads all 32 bits of `reg_wdata` on that clock edge, and index i reads the value back from then on.
- R2: When window i is selected, `pci_addr` = (register_i AND NOT mask_i) OR (`local_addr` AND mask_i), in the same cycle. The default masks are 0x00001FFF for window 0, 0x01FFFFFF for window 1 and 0x0000007F for window 2.
- R3: `win_sel` bit i selects window i. When several bits are set, the lowest index wins. When no bit is set, `pci_addr` is 0.
- R4: The device number field is bits [3:0] at index NUM_WIN and resets to 0. Bits [31:4] of that word always read 0, and writes to them have no effect.
- R5: A device number write whose bits [3:0] hold a value greater than NUM_IDSEL-1 is ignored, and the register keeps its previous value. A value of exactly NUM_IDSEL-1 is accepted.
- R6: `idsel_addr` is one-hot, with bit 16+d set, where d is the current device number.
- R7: If either INCLUDE_CONFIG or INCLUDE_DEVNUM is 0, index NUM_WIN reads 0, writes to it have no effect, and `idsel_addr` stays at bit 16 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | SLOT_W (2) | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| win_sel | input | NUM_WIN (3) | Window hit vector |
| local_addr | input | 32 | Local-bus address |
| pci_addr | output | 32 | Translated PCI address |
| idsel_addr | output | 32 | One-hot configuration select address bit |

## Verification
Several properties are checked on every cycle. A window write lands exactly as written. No hit gives a zero address. Window 0 passes its low bits through. The device number never reaches or passes NUM_IDSEL, and an out-of-range write leaves it unchanged. The select vector is always one-hot, and the upper bits of the device word always read zero. Other behaviour can only be shown by the bench's scenarios: the exact translated values for each window's mask, the priority between windows, the acceptance of the boundary value, and the register's absence in a build without the feature.

// File: rtl/pci_xlat_pkg.sv
`timescale 1ns/1ps
package pci_xlat_pkg;
    localparam int DEVNUM_W   = 4;
    localparam int IDSEL_BASE = 16;

    // true when the mask is a run of ones starting at bit 0 (or empty)
    function automatic bit mask_is_contig(input logic [31:0] m);
        logic [32:0] inc;
        inc = {1'b0, m} + 33'd1;
        return ((inc[31:0] & m) == 32'd0);
    endfunction
endpackage

// File: rtl/xlat_window.sv
`timescale 1ns/1ps
module xlat_window #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] MASK   = 32'h0000_1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] local_addr,
    output logic [ADDR_W-1:0] hi_q,
    output logic [ADDR_W-1:0] xlat_addr
);
    localparam logic [ADDR_W-1:0] PASS_MASK = MASK[ADDR_W-1:0];

    if (!pci_xlat_pkg::mask_is_contig(MASK)) begin : g_bad_mask
        $error("window mask must be contiguous from bit 0");
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (wr_en) begin
            hi_q <= wdata;
        end
    end

    always_comb begin
        xlat_addr = (hi_q & ~PASS_MASK) | (local_addr & PASS_MASK);
    end

    AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hi_q == $past(wdata));  // R1
endmodule

// File: rtl/dev_num_reg.sv
`timescale 1ns/1ps
module dev_num_reg #(
    parameter int ADDR_W    = 32,
    parameter int NUM_IDSEL = 16,
    parameter bit PRESENT   = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [pci_xlat_pkg::DEVNUM_W-1:0] wdata,
    output logic [pci_xlat_pkg::DEVNUM_W-1:0] dev_q,
    output logic [ADDR_W-1:0]                 idsel
);
    localparam int DW = pci_xlat_pkg::DEVNUM_W;
    localparam int IB = pci_xlat_pkg::IDSEL_BASE;
    localparam logic [DW:0] LIMIT = (DW+1)'(NUM_IDSEL);

    if (NUM_IDSEL < 1 || NUM_IDSEL > (1 << DW) || IB + NUM_IDSEL > ADDR_W) begin : g_bad_cfg
        $error("NUM_IDSEL out of range for the select address bits");
    end

    logic legal;
    assign legal = ({1'b0, wdata} < LIMIT);

    if (PRESENT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dev_q <= '0;
            end else if (wr_en && legal) begin
                dev_q <= wdata;
            end
        end
    end else begin : g_none
        assign dev_q = '0;
    end

    always_comb begin
        idsel = '0;
        idsel[IB + int'(dev_q)] = 1'b1;
    end

    AST_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, dev_q} < LIMIT);  // R5
    AST_DEV_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal) |=> $stable(dev_q));  // R5
    AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(idsel) == 1);  // R6
endmodule

// File: rtl/xlat_select.sv
`timescale 1ns/1ps
module xlat_select #(
    parameter int NUM_WIN = 3,
    parameter int ADDR_W  = 32
) (
    input  logic [NUM_WIN-1:0]             sel,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] cand,
    output logic [ADDR_W-1:0]              out
);
    always_comb begin
        out = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (sel[i]) out = cand[i];
        end
    end
endmodule

// File: rtl/pci_xlat_regs.sv
`timescale 1ns/1ps
module pci_xlat_regs #(
    parameter int ADDR_W         = 32,
    parameter int NUM_WIN        = 3,
    parameter logic [NUM_WIN-1:0][31:0] WIN_MASK =
        {32'h0000_007F, 32'h01FF_FFFF, 32'h0000_1FFF},
    parameter int NUM_IDSEL      = 16,
    parameter bit INCLUDE_CONFIG = 1'b1,
    parameter bit INCLUDE_DEVNUM = 1'b1,
    localparam int SLOT_W        = $clog2(NUM_WIN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [SLOT_W-1:0]  reg_addr,
    input  logic [ADDR_W-1:0]  reg_wdata,
    output logic [ADDR_W-1:0]  reg_rdata,
    input  logic [NUM_WIN-1:0] win_sel,
    input  logic [ADDR_W-1:0]  local_addr,
    output logic [ADDR_W-1:0]  pci_addr,
    output logic [ADDR_W-1:0]  idsel_addr
);
    localparam int DW = pci_xlat_pkg::DEVNUM_W;
    localparam logic [SLOT_W-1:0] DEV_SLOT = SLOT_W'(NUM_WIN);
    localparam logic [ADDR_W-1:0] MASK0 = WIN_MASK[0][ADDR_W-1:0];

    logic [NUM_WIN-1:0][ADDR_W-1:0] hi_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xlat;
    logic [DW-1:0]                  dev_q;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic wr_hit;
        assign wr_hit = reg_wr && (reg_addr == SLOT_W'(g));
        xlat_window #(
            .ADDR_W (ADDR_W),
            .MASK   (WIN_MASK[g])
        ) u_win (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_hit),
            .wdata      (reg_wdata),
            .local_addr (local_addr),
            .hi_q       (hi_q[g]),
            .xlat_addr  (xlat[g])
        );
    end

    xlat_select #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W)
    ) u_sel (
        .sel  (win_sel),
        .cand (xlat),
        .out  (pci_addr)
    );

    dev_num_reg #(
        .ADDR_W    (ADDR_W),
        .NUM_IDSEL (NUM_IDSEL),
        .PRESENT   (INCLUDE_CONFIG && INCLUDE_DEVNUM)
    ) u_dev (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr && (reg_addr == DEV_SLOT)),
        .wdata (reg_wdata[DW-1:0]),
        .dev_q (dev_q),
        .idsel (idsel_addr)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_addr == SLOT_W'(i)) reg_rdata = hi_q[i];
        end
        if (reg_addr == DEV_SLOT) reg_rdata = {{(ADDR_W-DW){1'b0}}, dev_q};
    end

    AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel == '0) |-> (pci_addr == '0));  // R3
    AST_WIN0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel[0] |-> (((pci_addr ^ local_addr) & MASK0) == '0));  // R2
    AST_DEV_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == DEV_SLOT) |-> (reg_rdata[ADDR_W-1:DW] == '0));  // R4
endmodule

// File: tb/pci_xlat_regs_test.sv
`timescale 1ns/1ps
module pci_xlat_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  win_sel = '0;
    logic [31:0] local_addr = '0;
    logic [31:0] reg_rdata, pci_addr, idsel_addr;
    logic [31:0] nd_rdata, nd_pci, nd_idsel;

    always #2.5 clk = ~clk;

    pci_xlat_regs #(.NUM_IDSEL(10)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_sel(win_sel),
        .local_addr(local_addr), .pci_addr(pci_addr), .idsel_addr(idsel_addr));

    pci_xlat_regs #(.NUM_IDSEL(10), .INCLUDE_DEVNUM(1'b0)) uut_nodev (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(nd_rdata), .win_sel(win_sel),
        .local_addr(local_addr), .pci_addr(nd_pci), .idsel_addr(nd_idsel));

    typedef struct {
        int          kind;   // 0 pci, 1 rdata, 2 idsel, 3 nodev rdata, 4 nodev idsel
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // monitor: compares everything pushed during this cycle
    always begin
        @(negedge clk);
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = pci_addr;
                1: act = reg_rdata;
                2: act = idsel_addr;
                3: act = nd_rdata;
                default: act = nd_idsel;
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic drive(input int kind, input logic [2:0] sel, input logic [31:0] la,
                         input logic [1:0] ra, input logic [31:0] exp, input string req);
        item_t it;
        @(posedge clk); #1;
        win_sel = sel; local_addr = la; reg_addr = ra;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state
        drive(1, 3'b000, 32'h0, 2'd0, 32'h0, "R1 win0 reset");
        drive(1, 3'b000, 32'h0, 2'd1, 32'h0, "R1 win1 reset");
        drive(1, 3'b000, 32'h0, 2'd2, 32'h0, "R1 win2 reset");
        drive(1, 3'b000, 32'h0, 2'd3, 32'h0, "R4 devnum reset");
        drive(2, 3'b000, 32'h0, 2'd3, 32'h0001_0000, "R6 idsel reset");
        drive(0, 3'b001, 32'hABCD_F123, 2'd0, 32'h0000_1123, "R2 reset regs");
        // program windows
        wr(2'd0, 32'hFEDC_0000);
        wr(2'd1, 32'h4000_0000);
        wr(2'd2, 32'h1234_5680);
        drive(1, 3'b000, 32'h0, 2'd0, 32'hFEDC_0000, "R1 win0 readback");
        drive(1, 3'b000, 32'h0, 2'd2, 32'h1234_5680, "R1 win2 readback");
        drive(0, 3'b001, 32'hABCD_F123, 2'd0, 32'hFEDC_1123, "R2 window 0");
        drive(0, 3'b010, 32'hFFFE_DCBA, 2'd0, 32'h41FE_DCBA, "R2 window 1");
        drive(0, 3'b100, 32'h0000_004A, 2'd0, 32'h1234_56CA, "R2 window 2");
        drive(0, 3'b000, 32'hABCD_F123, 2'd0, 32'h0, "R3 no hit");
        drive(0, 3'b011, 32'hABCD_F123, 2'd0, 32'hFEDC_1123, "R3 priority 0 over 1");
        drive(0, 3'b110, 32'h0000_004A, 2'd0, 32'h4000_004A, "R3 priority 1 over 2");
        wr(2'd2, 32'hFFFF_FFFF);
        drive(0, 3'b100, 32'h0000_0000, 2'd0, 32'hFFFF_FF80, "R2 masked reg bits");
        // device number
        wr(2'd3, 32'h0000_0005);
        drive(1, 3'b000, 32'h0, 2'd3, 32'h5, "R4 devnum write");
        drive(2, 3'b000, 32'h0, 2'd3, 32'h0020_0000, "R6 idsel dev 5");
        drive(3, 3'b000, 32'h0, 2'd3, 32'h0, "R7 absent reads zero");
        drive(4, 3'b000, 32'h0, 2'd3, 32'h0001_0000, "R7 absent idsel");
        wr(2'd3, 32'hFFFF_FFF7);
        drive(1, 3'b000, 32'h0, 2'd3, 32'h7, "R4 upper bits ignored");
        wr(2'd3, 32'h0000_000C);
        drive(1, 3'b000, 32'h0, 2'd3, 32'h7, "R5 over limit ignored");
        drive(2, 3'b000, 32'h0, 2'd3, 32'h0080_0000, "R6 idsel dev 7");
        wr(2'd3, 32'h0000_0009);
        drive(1, 3'b000, 32'h0, 2'd3, 32'h9, "R5 limit accepted");
        drive(2, 3'b000, 32'h0, 2'd3, 32'h0200_0000, "R6 idsel dev 9");
        wr(2'd3, 32'h0000_000A);
        drive(1, 3'b000, 32'h0, 2'd3, 32'h9, "R5 limit+1 ignored");
        drive(3, 3'b000, 32'h0, 2'd3, 32'h0, "R7 absent after writes");
        drive(4, 3'b000, 32'h0, 2'd3, 32'h0001_0000, "R7 absent idsel after writes");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule